// File: doc/BRIEF.md
# Streaming 3x3 Convolution Sequencer

This block is the control state machine for a streaming 3x3 convolution over an 8-bit grayscale image that is moved as 32-bit words, four pixels per word. On a start request it first preloads three image rows into the rolling row buffers. It then steps through each output row. For every row it waits out the registered-read latency of the buffers, shifts the window once per four-pixel step, and issues operand-valid pulses to the multiply-accumulate pipeline.

While one row is convolved, the read enable keeps fetching the next image row, so the buffers stay one row ahead. Each row has one convolution step fewer than it has words. The cycle right after the last step of a row therefore carries one extra read and no shift, and that read pulls the final word of the incoming row through the memory output register. After the last row the sequencer stays busy until the trailing results have left the MAC pipeline. It then pulses done.

The MAC datapath and the buffer storage sit outside the block. The sequencer tracks the MAC result-valid timing itself, using a valid pipeline that matches the MAC depth.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After reset, and in idle with no start, busy_o, rd_en_o, shift_en_o, mac_vld_o, out_vld_o and done_o are all 0.
- R2: A start_i sampled high in idle begins a frame. From the next cycle, rd_en_o is 1 for 3*WPR consecutive cycles, where WPR = IMG_W*PIX_W/WORD_W, to preload three rows. shift_en_o is 0 during these cycles.
- R3: Every output row begins with RD_LAT consecutive cycles in which rd_en_o, shift_en_o and mac_vld_o are all 0.
- R4: Every output row then has exactly WPR-1 consecutive cycles with shift_en_o and mac_vld_o both 1. A frame has IMG_H-2 output rows.
- R5: In the cycle after a row's final shift, shift_en_o is 0. rd_en_o is 1 during that row's shift cycles and during this cycle, except on the last output row, where it is 0 throughout.
- R6: A frame asserts rd_en_o in exactly IMG_H*WPR cycles.
- R7: out_vld_o equals mac_vld_o delayed by exactly MAC_LAT cycles.
- R8: done_o is a one-cycle pulse that comes exactly two cycles after the final out_vld_o of the frame. The cycles between them are drain cycles with all strobes 0.
- R9: start_i is ignored while busy_o is 1, including the done cycle. The frame timing is unchanged and exactly one done pulse is produced.
- R10: busy_o is 1 from the cycle after the accepted start through the done cycle, and 0 in the cycle after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request, sampled in idle |
| busy_o | output | 1 | Frame in progress |
| rd_en_o | output | 1 | Row buffer read enable, one word per cycle |
| shift_en_o | output | 1 | Window shift by one word |
| mac_vld_o | output | 1 | Operands valid into the MAC pipeline |
| out_vld_o | output | 1 | MAC result valid, mac_vld_o delayed by MAC_LAT |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench compares every strobe in every cycle of each frame against a cycle-indexed model built from the requirements. The targeted corner cases each expose a distinct fault:
- Row boundaries: a miscounted step counter makes a row one shift too long or too short.
- The read-latency gap: a missing wait lets the first shift use stale buffer data.
- The last-data cycle: losing its extra read leaves the reads per frame short by one word per row.
- The final row: an extra rolling read there overruns the image.
- Start pulses held long or scattered through a busy frame: a design that restarts shifts the done pulse or emits two.
- The drain length: a done that comes too early overlaps the last trailing MAC outputs.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_RUN,
    ST_LAST,
    ST_DRAIN,
    ST_DONE
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_cnt.sv
module seq_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/vld_pipe.sv
module vld_pipe #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  output logic vld_o
);

  logic [DEPTH-1:0] pipe_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= vld_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[DEPTH-2:0], vld_i};
      end
    end
  endgenerate

  assign vld_o = pipe_q[DEPTH-1];

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int IMG_W   = 512,
  parameter int IMG_H   = 512,
  parameter int PIX_W   = 8,
  parameter int WORD_W  = 32,
  parameter int RD_LAT  = 2,
  parameter int MAC_LAT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic rd_en_o,
  output logic shift_en_o,
  output logic mac_vld_o,
  output logic out_vld_o,
  output logic done_o
);

  localparam int LANES      = WORD_W / PIX_W;
  localparam int WPR        = IMG_W / LANES;
  localparam int STEPS      = WPR - 1;
  localparam int ROWS       = IMG_H - 2;
  localparam int FILL_WORDS = 3 * WPR;
  localparam int CNT_MAX    = max3(FILL_WORDS, RD_LAT, MAC_LAT);
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int RD_TOTAL   = IMG_H * WPR;
  localparam int TALLY_W    = $clog2(RD_TOTAL + 1);

  localparam logic [CNT_W-1:0] FILL_END  = CNT_W'(FILL_WORDS - 1);
  localparam logic [CNT_W-1:0] WAIT_END  = CNT_W'(RD_LAT - 1);
  localparam logic [CNT_W-1:0] RUN_END   = CNT_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] DRAIN_END = CNT_W'(MAC_LAT - 1);
  localparam logic [ROW_W-1:0] ROW_END   = ROW_W'(ROWS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] step_q;
  logic [ROW_W-1:0] row_q;
  logic             last_row;
  logic             step_clr;
  logic             row_clr, row_inc;

  assign last_row = (row_q == ROW_END);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)              state_d = ST_FILL;
      ST_FILL:  if (step_q == FILL_END)   state_d = ST_WAIT;
      ST_WAIT:  if (step_q == WAIT_END)   state_d = ST_RUN;
      ST_RUN:   if (step_q == RUN_END)    state_d = ST_LAST;
      ST_LAST:  state_d = last_row ? ST_DRAIN : ST_WAIT;
      ST_DRAIN: if (step_q == DRAIN_END)  state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // step counter restarts on every state change
  assign step_clr = (state_d != state_q);
  assign row_clr  = (state_q == ST_IDLE);
  assign row_inc  = (state_q == ST_LAST) && !last_row;

  seq_cnt #(.CNT_W(CNT_W)) i_step_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (step_clr),
    .inc_i  (1'b1),
    .cnt_o  (step_q)
  );

  seq_cnt #(.CNT_W(ROW_W)) i_row_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (row_clr),
    .inc_i  (row_inc),
    .cnt_o  (row_q)
  );

  // rolling fetch of the next row overlaps the current row's convolution
  assign rd_en_o    = (state_q == ST_FILL) ||
                      (((state_q == ST_RUN) || (state_q == ST_LAST)) && !last_row);
  assign shift_en_o = (state_q == ST_RUN);
  assign mac_vld_o  = (state_q == ST_RUN);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  vld_pipe #(.DEPTH(MAC_LAT)) i_vld_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (mac_vld_o),
    .vld_o  (out_vld_o)
  );

  // checker state
  logic [CNT_W-1:0]   shift_run_q;
  logic [TALLY_W-1:0] rd_tally_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shift_run_q <= '0;
    else if (shift_en_o) shift_run_q <= shift_run_q + 1'b1;
    else                 shift_run_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_tally_q <= '0;
    else if (!busy_o) rd_tally_q <= '0;
    else if (rd_en_o) rd_tally_q <= rd_tally_q + 1'b1;
  end

  AST_FILL_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> rd_en_o && !shift_en_o && $past(start_i)); // R2
  AST_READ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shift_en_o) |-> $past(!rd_en_o && !shift_en_o && busy_o)); // R3
  AST_ROW_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |-> (shift_run_q < RUN_END + 1'b1)); // R4
  AST_ROW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shift_en_o) |-> (shift_run_q == CNT_W'(STEPS))); // R4
  AST_READ_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_tally_q == TALLY_W'(RD_TOTAL))); // R6
  AST_OUT_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> busy_o && !done_o); // R7
  AST_DONE_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_vld_o && $past(!out_vld_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R10
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R9

endmodule

// File: tb/test_conv_seq_ctrl.sv
`timescale 1ns/1ps
module test_conv_seq_ctrl;

  localparam int IMG_W   = 32;
  localparam int IMG_H   = 6;
  localparam int PIX_W   = 8;
  localparam int WORD_W  = 32;
  localparam int RD_LAT  = 2;
  localparam int MAC_LAT = 3;
  localparam int WPR     = IMG_W * PIX_W / WORD_W;
  localparam int ROWS    = IMG_H - 2;
  localparam int SEG     = RD_LAT + WPR;
  localparam int FILL    = 3 * WPR;
  localparam int FRAME   = FILL + ROWS * SEG + MAC_LAT + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, rd_en_o, shift_en_o, mac_vld_o, out_vld_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  conv_seq_ctrl #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W), .WORD_W(WORD_W),
    .RD_LAT(RD_LAT), .MAC_LAT(MAC_LAT)
  ) i_conv_seq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
    .rd_en_o(rd_en_o), .shift_en_o(shift_en_o), .mac_vld_o(mac_vld_o),
    .out_vld_o(out_vld_o), .done_o(done_o)
  );

  // {busy, rd, shift, done} for cycle n after the accepted start
  function automatic logic [3:0] exp_at(input int n);
    int m, k, p, q;
    logic more;
    if (n < 1 || n > FRAME) return 4'b0000;
    if (n <= FILL) return 4'b1100;
    m = n - FILL - 1;
    if (m < ROWS * SEG) begin
      k = m / SEG;
      p = m % SEG;
      more = (k < ROWS - 1);
      if (p < RD_LAT) return 4'b1000;
      if (p < RD_LAT + WPR - 1) return {1'b1, more, 2'b10};
      return {1'b1, more, 2'b00};
    end
    q = m - ROWS * SEG;
    if (q < MAC_LAT) return 4'b1000;
    return 4'b1001;
  endfunction

  function automatic string tag_at(input int n);
    int m, p;
    if (n < 1 || n > FRAME) return "R1";
    if (n <= FILL) return "R2";
    m = n - FILL - 1;
    if (m >= ROWS * SEG) return "R8";
    p = m % SEG;
    if (p < RD_LAT) return "R3";
    if (p < RD_LAT + WPR - 1) return "R4";
    return "R5";
  endfunction

  task automatic chk(input logic act, input logic exp, input string what, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_frame(input int hold, input int noise_pct);
    int rd_cnt = 0, sh_cnt = 0, ov_cnt = 0, dn_cnt = 0;
    logic [3:0] e, eo;
    string t;
    @(negedge clk_i);
    start_i = 1'b1;
    for (int n = 1; n <= FRAME + 1; n++) begin
      @(negedge clk_i);
      e  = exp_at(n);
      eo = exp_at(n - MAC_LAT);
      t  = tag_at(n);
      chk(busy_o, e[3], "busy", (n > FRAME) ? "R10" : t);
      chk(rd_en_o, e[2], "rd_en", t);
      chk(shift_en_o, e[1], "shift_en", t);
      chk(mac_vld_o, e[1], "mac_vld", t);
      chk(done_o, e[0], "done", (n == FRAME) ? "R8" : t);
      chk(out_vld_o, eo[1], "out_vld", "R7");
      rd_cnt += int'(rd_en_o);
      sh_cnt += int'(shift_en_o);
      ov_cnt += int'(out_vld_o);
      dn_cnt += int'(done_o);
      if (n == FRAME + 1) start_i = 1'b0;
      else start_i = (n < hold) || (int'($urandom_range(99)) < noise_pct);
    end
    chk_int(rd_cnt, IMG_H * WPR, "reads per frame", "R6");
    chk_int(sh_cnt, ROWS * (WPR - 1), "shifts per frame", "R4");
    chk_int(ov_cnt, ROWS * (WPR - 1), "results per frame", "R7");
    chk_int(dn_cnt, 1, "done pulses with busy starts", "R9");
  endtask

  task automatic idle_gap(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      chk(busy_o, 1'b0, "idle busy", "R1");
      chk(rd_en_o | shift_en_o | mac_vld_o | out_vld_o | done_o, 1'b0, "idle strobes", "R1");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk(busy_o | rd_en_o | shift_en_o | mac_vld_o | out_vld_o | done_o, 1'b0, "in reset", "R1");
    rst_ni = 1'b1;
    idle_gap(3);
    run_frame(1, 0);          // plain frame
    idle_gap(2);
    run_frame(FRAME + 1, 0);  // start held through the whole frame, R9
    idle_gap(1);
    run_frame(1, 50);         // scattered starts while busy, R9
    run_frame(2, 0);          // back to back
    for (int f = 0; f < 16; f++) begin
      idle_gap(int'($urandom_range(3)));
      run_frame(1 + int'($urandom_range(4)), int'($urandom_range(60)));
    end
    idle_gap(2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule